// File: doc/BRIEF.md
# Interrupt Field Register Bank

This block holds the interrupt enable masks and priority levels of an interrupt controller. Each register is split into fields, and each field belongs to one interrupt source or source group. Mask registers have one-bit fields and two addresses: one alias sets bits and the other clears them. Priority registers have multi-bit fields and one address, which is written directly.

Every accepted write compares each field of the old value with the same field of the new value. For every field whose value changed, the block emits one event on its output stream. The event carries the identifier of the field's source and an enable flag. A reader downstream, such as the pending-interrupt logic, uses these events to keep its per-source enable state. While events are still being sent, the block shows busy and ignores writes.

Top module: `irq_field_bank`

## Requirements
- R1: Address decoding compares only bits 28..0 of `addr`. Bits 31..29 do not affect which register is selected.
- R2: A write to a mask register's set alias stores the old value OR `wdata`.
- R3: A write to a mask register's clear alias stores the old value AND NOT `wdata`.
- R4: A write to a priority register stores `wdata` unchanged.
- R5: After reset, all registers hold zero. `rd_data` always shows the stored value of the register that `addr` selects, and either alias of a mask register reads the same value.
- R6: A write to an address that selects no register changes nothing and starts no events. A read from such an address gives zero.
- R7: An event is produced only for a field whose bits differ between the old and new value. A write that changes no field leaves `busy` low.
- R8: Fields are numbered from the most significant end. Field k covers `FW` bits starting at bit (NF-1-k)*FW, where FW is 1 for mask registers and `PRI_FW` for priority registers.
  - Its event identifier is base + k. The base is `MSK_ID_BASE + i*REG_W` for mask register i and `PRI_ID_BASE + j*(REG_W/PRI_FW)` for priority register j.
  - `evt_en` is 1 when the new field value is nonzero.
- R9: The events of one write appear one per cycle, in increasing field number. The first event appears the cycle after the write is accepted.
- R10: `busy` is high exactly while events remain to be sent. A write presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Register address, used for both reads and writes |
| wdata | input | REG_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | REG_W | Stored value of the selected register, or zero if no register is selected |
| busy | output | 1 | Events outstanding; writes are ignored |
| evt_valid | output | 1 | An event is presented this cycle |
| evt_id | output | ID_W | Source or group identifier of the changed field |
| evt_en | output | 1 | 1 = enable (new field nonzero), 0 = disable |

## Verification
The bench runs the following directed patterns:
- Set-alias writes to a cleared register. These show the most significant field mapping to the lowest identifier.
- Clear-alias writes that hit both set and already-clear bits. These show that unchanged fields produce no event.
- A set write that repeats bits already set. This shows that a no-change write leaves `busy` low.
- Direct priority writes where only some fields change, including a field returning to zero. These separate the nonzero-enable rule from the per-bit rule.
- A full-width burst followed by a write during `busy`. This shows that the second write is dropped.
- Addresses with high bits set, and unmapped addresses. These test the 29-bit decode and the zero read.

A pseudo-random write and read mix then compares the block against the behavioural model on every cycle.

// File: rtl/fbank_pkg.sv
package fbank_pkg;

    // How a decoded address modifies its register
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_SET    = 2'd1,
        ACC_CLR    = 2'd2,
        ACC_DIRECT = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/fbank_decode.sv
module fbank_decode
    import fbank_pkg::*;
#(
    parameter int          N_MSK        = 2,
    parameter int          N_PRI        = 2,
    parameter int          IDX_W        = 2,
    parameter logic [31:0] MSK_SET_BASE = 32'h0000_0040,
    parameter logic [31:0] MSK_CLR_BASE = 32'h0000_0060,
    parameter logic [31:0] PRI_BASE     = 32'h0000_0080,
    parameter int          ADDR_STRIDE  = 4
) (
    input  logic [28:0]      addr_lo,
    output logic             hit,
    output acc_mode_e        mode,
    output logic [IDX_W-1:0] idx
);

    logic [N_MSK-1:0] set_hit;
    logic [N_MSK-1:0] clr_hit;
    logic [N_PRI-1:0] pri_hit;

    // One comparator per alias; only the low 29 address bits take part
    for (genvar i = 0; i < N_MSK; i++) begin : g_msk
        localparam logic [31:0] SET_A = MSK_SET_BASE + 32'(i * ADDR_STRIDE);
        localparam logic [31:0] CLR_A = MSK_CLR_BASE + 32'(i * ADDR_STRIDE);
        assign set_hit[i] = (addr_lo == SET_A[28:0]);
        assign clr_hit[i] = (addr_lo == CLR_A[28:0]);
    end

    for (genvar j = 0; j < N_PRI; j++) begin : g_pri
        localparam logic [31:0] PRI_A = PRI_BASE + 32'(j * ADDR_STRIDE);
        assign pri_hit[j] = (addr_lo == PRI_A[28:0]);
    end

    always_comb begin
        hit  = 1'b0;
        mode = ACC_NONE;
        idx  = '0;
        for (int r = 0; r < N_MSK; r++) begin
            if (!hit && set_hit[r]) begin
                hit  = 1'b1;
                mode = ACC_SET;
                idx  = IDX_W'(r);
            end else if (!hit && clr_hit[r]) begin
                hit  = 1'b1;
                mode = ACC_CLR;
                idx  = IDX_W'(r);
            end
        end
        for (int p = 0; p < N_PRI; p++) begin
            if (!hit && pri_hit[p]) begin
                hit  = 1'b1;
                mode = ACC_DIRECT;
                idx  = IDX_W'(N_MSK + p);
            end
        end
    end

endmodule

// File: rtl/fbank_field_diff.sv
module fbank_field_diff #(
    parameter int W  = 16,
    parameter int FW = 4,
    localparam int NF = W / FW
) (
    input  logic [W-1:0]  old_v,
    input  logic [W-1:0]  new_v,
    output logic [NF-1:0] chg,
    output logic [NF-1:0] nz
);

    // Field k is numbered from the top of the register downward
    for (genvar k = 0; k < NF; k++) begin : g_fld
        localparam int LSB = (NF - 1 - k) * FW;
        assign chg[k] = (old_v[LSB +: FW] != new_v[LSB +: FW]);
        assign nz[k]  = |new_v[LSB +: FW];
    end

endmodule

// File: rtl/fbank_pick.sv
module fbank_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] first,
    output logic [N-1:0]  first_oh
);

    // Lowest set index wins
    always_comb begin
        any      = |req;
        first    = '0;
        first_oh = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                first       = IW'(k);
                first_oh    = '0;
                first_oh[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_field_bank.sv
module irq_field_bank
    import fbank_pkg::*;
#(
    parameter int          REG_W        = 16,
    parameter int          N_MSK        = 2,
    parameter int          N_PRI        = 2,
    parameter int          PRI_FW       = 4,
    parameter int          ID_W         = 8,
    parameter logic [31:0] MSK_SET_BASE = 32'h0000_0040,
    parameter logic [31:0] MSK_CLR_BASE = 32'h0000_0060,
    parameter logic [31:0] PRI_BASE     = 32'h0000_0080,
    parameter int          ADDR_STRIDE  = 4,
    parameter int          MSK_ID_BASE  = 1,
    parameter int          PRI_ID_BASE  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wr_en,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             evt_valid,
    output logic [ID_W-1:0]  evt_id,
    output logic             evt_en
);

    localparam int NREG   = N_MSK + N_PRI;
    localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int PRI_NF = REG_W / PRI_FW;
    localparam int KW     = (REG_W > 1) ? $clog2(REG_W) : 1;

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
        logic [REG_W-1:0]           chg;   // fields still to report
        logic [REG_W-1:0]           nz;    // new value nonzero, per field
        logic [ID_W-1:0]            base;  // identifier of field 0
    } state_t;

    state_t s_d, s_q;

    logic             hit;
    acc_mode_e        mode;
    logic [IDX_W-1:0] idx;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^addr[31:29];

    fbank_decode #(
        .N_MSK       (N_MSK),
        .N_PRI       (N_PRI),
        .IDX_W       (IDX_W),
        .MSK_SET_BASE(MSK_SET_BASE),
        .MSK_CLR_BASE(MSK_CLR_BASE),
        .PRI_BASE    (PRI_BASE),
        .ADDR_STRIDE (ADDR_STRIDE)
    ) u_dec (
        .addr_lo(addr[28:0]),
        .hit    (hit),
        .mode   (mode),
        .idx    (idx)
    );

    logic [REG_W-1:0] old_v, new_v;

    always_comb begin
        old_v = s_q.regs[idx];
        case (mode)
            ACC_SET:    new_v = old_v | wdata;
            ACC_CLR:    new_v = old_v & ~wdata;
            ACC_DIRECT: new_v = wdata;
            default:    new_v = old_v;
        endcase
    end

    logic [REG_W-1:0]  chg_m, nz_m;
    logic [PRI_NF-1:0] chg_p, nz_p;

    fbank_field_diff #(.W(REG_W), .FW(1)) u_diff_msk (
        .old_v(old_v), .new_v(new_v), .chg(chg_m), .nz(nz_m)
    );

    fbank_field_diff #(.W(REG_W), .FW(PRI_FW)) u_diff_pri (
        .old_v(old_v), .new_v(new_v), .chg(chg_p), .nz(nz_p)
    );

    logic             pend_any;
    logic [KW-1:0]    pend_k;
    logic [REG_W-1:0] pend_oh;

    fbank_pick #(.N(REG_W), .IW(KW)) u_pick (
        .req     (s_q.chg),
        .any     (pend_any),
        .first   (pend_k),
        .first_oh(pend_oh)
    );

    always_comb begin
        s_d = s_q;
        if (pend_any) begin
            // drain one event per cycle; writes are dropped meanwhile
            s_d.chg = s_q.chg & ~pend_oh;
        end else if (wr_en && hit) begin
            s_d.regs[idx] = new_v;
            if (int'(idx) < N_MSK) begin
                s_d.chg  = chg_m;
                s_d.nz   = nz_m;
                s_d.base = ID_W'(MSK_ID_BASE + int'(idx) * REG_W);
            end else begin
                s_d.chg  = REG_W'(chg_p);
                s_d.nz   = REG_W'(nz_p);
                s_d.base = ID_W'(PRI_ID_BASE + (int'(idx) - N_MSK) * PRI_NF);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data   = hit ? s_q.regs[idx] : '0;
    assign busy      = pend_any;
    assign evt_valid = pend_any;
    assign evt_id    = s_q.base + ID_W'(pend_k);
    assign evt_en    = s_q.nz[pend_k];

endmodule

// File: rtl/fbank_checks.sv
module fbank_checks #(
    parameter int          REG_W = 16,
    parameter int          NREG  = 4,
    parameter int          ID_W  = 8,
    parameter logic [31:0] SET0  = 32'h0000_0040,
    parameter logic [31:0] CLR0  = 32'h0000_0060
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [31:0]                addr,
    input logic                       wr_en,
    input logic                       busy,
    input logic                       evt_valid,
    input logic [ID_W-1:0]            evt_id,
    input logic [NREG-1:0][REG_W-1:0] regs
);

    logic unused_chk_hi;
    assign unused_chk_hi = ^addr[31:29];

    // R10: no register moves while events are draining
    a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(regs));

    // R2: the set alias never removes a bit
    a_r2_set_only_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr[28:0] == SET0[28:0])
        |=> ((regs[0] & $past(regs[0])) == $past(regs[0])));

    // R3: the clear alias never adds a bit
    a_r3_clr_only_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr[28:0] == CLR0[28:0])
        |=> ((regs[0] | $past(regs[0])) == $past(regs[0])));

    // R7: a burst of events always follows a write
    a_r7_burst_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R9: within a burst, identifiers strictly increase
    a_r9_ids_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && $past(evt_valid)) |-> (evt_id > $past(evt_id)));

endmodule

bind irq_field_bank fbank_checks #(
    .REG_W(REG_W),
    .NREG (NREG),
    .ID_W (ID_W),
    .SET0 (MSK_SET_BASE),
    .CLR0 (MSK_CLR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .busy     (busy),
    .evt_valid(evt_valid),
    .evt_id   (evt_id),
    .regs     (s_q.regs)
);

// File: tb/sim_irq_field_bank.sv
module sim_irq_field_bank;

    localparam int REG_W = 16, N_MSK = 2, N_PRI = 2, PRI_FW = 4, ID_W = 8;
    localparam int PRI_NF = REG_W / PRI_FW;
    localparam logic [31:0] SET0 = 32'h40, CLR0 = 32'h60, PRI0 = 32'h80;
    localparam int STRIDE = 4, MSK_ID0 = 1, PRI_ID0 = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      addr = '0;
    logic [REG_W-1:0] wdata = '0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] rd_data;
    logic             busy, evt_valid, evt_en;
    logic [ID_W-1:0]  evt_id;

    always #4 clk = ~clk;   // 125 MHz

    irq_field_bank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_data(rd_data), .busy(busy), .evt_valid(evt_valid),
        .evt_id(evt_id), .evt_en(evt_en)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [REG_W-1:0] m_msk [N_MSK];
    logic [REG_W-1:0] m_pri [N_PRI];
    int evq[$];   // id*2 + enable

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] m_read(input logic [31:0] a);
        for (int i = 0; i < N_MSK; i++)
            if (a[28:0] == 29'(SET0 + i*STRIDE) || a[28:0] == 29'(CLR0 + i*STRIDE))
                return m_msk[i];
        for (int j = 0; j < N_PRI; j++)
            if (a[28:0] == 29'(PRI0 + j*STRIDE)) return m_pri[j];
        return '0;
    endfunction

    task automatic model_step(input logic we, input logic [31:0] a,
                              input logic [REG_W-1:0] d);
        logic [REG_W-1:0] o, n;
        if (evq.size() != 0) begin
            void'(evq.pop_front());
        end else if (we) begin
            for (int i = 0; i < N_MSK; i++) begin
                if (a[28:0] == 29'(SET0 + i*STRIDE) || a[28:0] == 29'(CLR0 + i*STRIDE)) begin
                    o = m_msk[i];
                    n = (a[28:0] == 29'(SET0 + i*STRIDE)) ? (o | d) : (o & ~d);
                    for (int k = 0; k < REG_W; k++)
                        if (o[REG_W-1-k] != n[REG_W-1-k])
                            evq.push_back((MSK_ID0 + i*REG_W + k)*2 + int'(n[REG_W-1-k]));
                    m_msk[i] = n;
                end
            end
            for (int j = 0; j < N_PRI; j++) begin
                if (a[28:0] == 29'(PRI0 + j*STRIDE)) begin
                    o = m_pri[j];
                    n = d;
                    for (int k = 0; k < PRI_NF; k++)
                        if (o[(PRI_NF-1-k)*PRI_FW +: PRI_FW] != n[(PRI_NF-1-k)*PRI_FW +: PRI_FW])
                            evq.push_back((PRI_ID0 + j*PRI_NF + k)*2 +
                                          int'(|n[(PRI_NF-1-k)*PRI_FW +: PRI_FW]));
                    m_pri[j] = n;
                end
            end
        end
    endtask

    task automatic compare_all();
        chk("R10", 64'(busy), 64'(evq.size() != 0), "busy");
        chk("R9", 64'(evt_valid), 64'(evq.size() != 0), "evt_valid");
        if (evq.size() != 0) begin
            chk("R8", 64'(evt_id), 64'(evq[0] >> 1), "evt_id");
            chk("R8", 64'(evt_en), 64'(evq[0] & 1), "evt_en");
        end
        chk("R5", 64'(rd_data), 64'(m_read(addr)), "rd_data");
    endtask

    // One clock: check outputs, then present the next inputs
    task automatic cycle(input logic we, input logic [31:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        compare_all();
        wr_en = we; addr = a; wdata = d;
        model_step(we, a, d);
    endtask

    task automatic drain();
        while (evq.size() != 0) cycle(1'b0, addr, '0);
        cycle(1'b0, addr, '0);
    endtask

    task automatic rd_expect(input logic [31:0] a, input logic [REG_W-1:0] exp, input string req);
        cycle(1'b0, a, '0);
        #1 chk(req, 64'(rd_data), 64'(exp), "read");
    endtask

    task automatic evt_expect(input int id, input logic en, input string req);
        cycle(1'b0, addr, '0);
        #1;
        chk(req, 64'(evt_valid), 64'd1, "evt_valid");
        chk(req, 64'(evt_id), 64'(id), "evt_id");
        chk(req, 64'(evt_en), 64'(en), "evt_en");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] pick;
        for (int i = 0; i < N_MSK; i++) m_msk[i] = '0;
        for (int j = 0; j < N_PRI; j++) m_pri[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        addr = SET0;
        #1;
        // R5: reset state
        chk("R5", 64'(rd_data), 64'd0, "reset read");
        chk("R10", 64'(busy), 64'd0, "reset busy");

        // R2 / R8 / R9: set alias, MSB field gets the lowest identifier
        cycle(1'b1, SET0, 16'h8001);
        evt_expect(1, 1'b1, "R8");
        evt_expect(16, 1'b1, "R9");
        drain();
        rd_expect(SET0, 16'h8001, "R2");
        rd_expect(CLR0, 16'h8001, "R5");

        // R1: high address bits ignored
        cycle(1'b1, 32'hE000_0040, 16'h0100);
        evt_expect(8, 1'b1, "R1");
        drain();
        rd_expect(32'h40, 16'h8101, "R1");
        rd_expect(32'hA000_0060, 16'h8101, "R1");

        // R3 / R7: clear alias; bit 1 already clear gives no event
        cycle(1'b1, CLR0, 16'h8002);
        evt_expect(1, 1'b0, "R3");
        cycle(1'b0, SET0, '0);
        #1 chk("R7", 64'(evt_valid), 64'd0, "no event for unchanged bit");
        rd_expect(SET0, 16'h0101, "R3");

        // R7: write that changes nothing
        cycle(1'b1, SET0, 16'h0001);
        cycle(1'b0, SET0, '0);
        #1 chk("R7", 64'(busy), 64'd0, "busy after no-change write");

        // R4 / R8: priority register, direct write, partial field change
        cycle(1'b1, PRI0, 16'h3050);
        evt_expect(40, 1'b1, "R4");
        evt_expect(42, 1'b1, "R8");
        drain();
        rd_expect(PRI0, 16'h3050, "R4");
        cycle(1'b1, PRI0, 16'h3000);
        evt_expect(42, 1'b0, "R8");
        drain();
        cycle(1'b1, PRI0 + 4, 16'h000F);
        evt_expect(47, 1'b1, "R8");
        drain();

        // R10: write during a burst is dropped
        cycle(1'b1, SET0 + 4, 16'hFFFF);
        cycle(1'b1, SET0, 16'hFFFF);
        #1 chk("R10", 64'(evt_id), 64'd17, "first id of burst");
        drain();
        rd_expect(SET0, 16'h0101, "R10");
        rd_expect(CLR0 + 4, 16'hFFFF, "R5");

        // R6: unmapped addresses
        cycle(1'b1, 32'h100, 16'hFFFF);
        cycle(1'b0, 32'h100, '0);
        #1 chk("R6", 64'(busy), 64'd0, "busy after unmapped write");
        chk("R6", 64'(rd_data), 64'd0, "unmapped read");
        rd_expect(32'h90, 16'h0000, "R6");

        // Mixed traffic against the model
        lfsr = 32'h1ACE_B00C;
        for (int t = 0; t < 600; t++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[2:0])
                3'd0: pick = SET0;
                3'd1: pick = CLR0;
                3'd2: pick = SET0 + 4;
                3'd3: pick = CLR0 + 4;
                3'd4: pick = PRI0;
                3'd5: pick = PRI0 + 4;
                3'd6: pick = 32'h100;
                default: pick = 32'hE000_0064;
            endcase
            cycle(lfsr[5] | lfsr[9], pick, lfsr[27:12]);
        end
        drain();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule